// File: doc/BRIEF.md
# Beat-Note Phase Estimator

This block measures the phase of a digitised optical beat signal. Each ADC sample is multiplied by an internal quadrature local oscillator running at the expected beat frequency. The two products are decimated by a pair of third-order CIC filters and rescaled by a programmable right shift. A four-quadrant iterative CORDIC then turns the decimated I and Q pair into an angle. One phase word and a one-cycle valid strobe appear per decimation window.

The oscillator frequency word normally comes from the synthesiser frequency-difference word, shifted left to account for the frequency multiplication in the optical path. A select bit can replace it with a fixed word for testing. The decimation ratio is a power of two chosen at run time. The reported phase has an arbitrary constant offset, so users read phase changes rather than absolute values.

Top module: `beat_phase_est`

## Requirements
- R1: With `use_fixed_i` low, the oscillator frequency word is `diff_word_i << shift_i`, truncated to FREQ_W bits. Bits shifted above the top are lost.
- R2: With `use_fixed_i` high, the oscillator runs at `fixed_word_i`, and `diff_word_i` and `shift_i` have no effect.
- R3: For a decimation exponent R (clamped to RMAX, with 2^R greater than CORDIC_ITER+1), `phase_valid_o` is a single-cycle pulse that repeats exactly every 2^R clock cycles.
- R4: Each I/Q channel is a three-integrator, three-comb filter with DC gain 2^(3R). Its output is arithmetically shifted right by `cic_shift_i` and clamped to ±(2^(CORE_W-1)-1). When both channels clamp positive, the phase reads π/4, which is 2^(PHASE_W-3) codes.
- R5: The phase covers all four quadrants, with 2^(PHASE_W-1) codes equal to π. A step Δ in input phase moves `phase_o` by Δ·2^PHASE_W/2π codes, positive when the input leads. `phase_o` changes only in a cycle where `phase_valid_o` is high.
- R6: A frequency mismatch δ between the input and the oscillator words rotates the phase by -δ·2^R/2^FREQ_W turns per output.
- R7: A change of `cic_rate_i` clears the integrators, combs, decimation counter and any CORDIC job in progress. No strobe comes in the following cycle, and the first new strobe comes no sooner than 2^R cycles later.
- R8: While `rst` is high, `phase_valid_o` is low and `phase_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_i | input | ADC_W | Signed ADC sample, one per cycle |
| diff_word_i | input | FREQ_W | Synthesiser frequency-difference word |
| shift_i | input | SHIFT_W | Left shift applied to the difference word |
| fixed_word_i | input | FREQ_W | Fixed oscillator word for test |
| use_fixed_i | input | 1 | Selects the fixed word |
| cic_rate_i | input | RATE_W | Decimation exponent R |
| cic_shift_i | input | CSH_W | Right shift after the CIC |
| phase_o | output | PHASE_W | Phase word, full scale ±π |
| phase_valid_o | output | 1 | One-cycle strobe per new phase |

## Verification
The bench builds the block with its default parameters: 14-bit samples, a 32-bit oscillator, 24-bit core values, 16 CORDIC iterations and a 16-bit phase. It runs the filter at R=6 and R=8, so each window holds a whole number of periods of a beat at one sixteenth of the sample rate. Phase steps and frequency offsets then give exact expected code changes. With a zero post-filter shift, both channels clamp, which brings the saturation corner within reach.

// File: rtl/beat_pe_pkg.sv
package beat_pe_pkg;

    localparam int ANG_W = 32;

    // arctan(2^-i) in units where 2^31 represents pi
    function automatic logic [ANG_W-1:0] atan_word(input int unsigned idx);
        logic [ANG_W-1:0] w;
        case (idx)
            0:  w = 32'd536870912;
            1:  w = 32'd316933406;
            2:  w = 32'd167458907;
            3:  w = 32'd85004756;
            4:  w = 32'd42667331;
            5:  w = 32'd21354465;
            6:  w = 32'd10679838;
            7:  w = 32'd5340245;
            8:  w = 32'd2670163;
            9:  w = 32'd1335087;
            10: w = 32'd667544;
            11: w = 32'd333772;
            12: w = 32'd166886;
            13: w = 32'd83443;
            14: w = 32'd41722;
            15: w = 32'd20861;
            default: w = 32'd683565276 >> idx;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/beat_pe_nco.sv
module beat_pe_nco #(
    parameter int FREQ_W  = 32,
    parameter int SHIFT_W = 4,
    parameter int LO_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [FREQ_W-1:0]        diff_word_i,
    input  logic [SHIFT_W-1:0]       shift_i,
    input  logic [FREQ_W-1:0]        fixed_word_i,
    input  logic                     use_fixed_i,
    output logic signed [LO_W-1:0]   cos_o,
    output logic signed [LO_W-1:0]   nsin_o
);
    localparam int IDX_W  = 16;
    localparam int MAG_SH = 2 * IDX_W - 2 - LO_W;
    localparam logic [IDX_W-1:0] QUARTER = IDX_W'(1) << (IDX_W - 2);
    localparam logic [IDX_W-1:0] HALF    = IDX_W'(1) << (IDX_W - 1);

    typedef struct packed {
        logic [FREQ_W-1:0]      acc;
        logic signed [LO_W-1:0] cosv;
        logic signed [LO_W-1:0] nsinv;
    } nco_t;

    nco_t s_d, s_q;
    logic [FREQ_W-1:0] word;
    logic [IDX_W-1:0]  idx;

    // parabolic half-wave: 4f(1-f), sign from the top index bit
    function automatic logic signed [LO_W-1:0] wave(input logic [IDX_W-1:0] p);
        logic [IDX_W-1:0]   fe;
        logic [IDX_W-1:0]   ce;
        logic [2*IDX_W-1:0] prod;
        logic signed [LO_W-1:0] mag;
        fe   = {1'b0, p[IDX_W-2:0]};
        ce   = HALF - fe;
        prod = (2*IDX_W)'(fe) * (2*IDX_W)'(ce);
        mag  = LO_W'(prod >> MAG_SH);
        return p[IDX_W-1] ? -mag : mag;
    endfunction

    always_comb begin
        s_d       = s_q;
        word      = use_fixed_i ? fixed_word_i : (diff_word_i << shift_i);
        idx       = s_q.acc[FREQ_W-1 -: IDX_W];
        s_d.acc   = s_q.acc + word;
        s_d.cosv  = wave(idx + QUARTER);
        s_d.nsinv = -wave(idx);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cos_o  = s_q.cosv;
    assign nsin_o = s_q.nsinv;

endmodule

// File: rtl/beat_pe_cic.sv
module beat_pe_cic #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 55,
    parameter int OUT_W = 24,
    parameter int CSH_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear_i,
    input  logic signed [IN_W-1:0]   sample_i,
    input  logic                     dump_i,
    input  logic [CSH_W-1:0]         shift_i,
    output logic signed [OUT_W-1:0]  out_o,
    output logic                     valid_o
);
    localparam int NST = 3;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI;

    typedef struct packed {
        logic [NST-1:0][ACC_W-1:0] integ;
        logic [NST-1:0][ACC_W-1:0] dly;
        logic [OUT_W-1:0]          out;
        logic                      valid;
    } cic_t;

    cic_t s_d, s_q;
    logic [ACC_W-1:0]        stage;
    logic [ACC_W-1:0]        nxt;
    logic signed [ACC_W-1:0] shifted;
    logic signed [ACC_W-1:0] clamped;

    always_comb begin
        s_d          = s_q;
        s_d.valid    = 1'b0;
        s_d.integ[0] = s_q.integ[0] + ACC_W'(sample_i);
        for (int k = 1; k < NST; k++) begin
            s_d.integ[k] = s_q.integ[k] + s_q.integ[k-1];
        end
        stage = s_q.integ[NST-1];
        for (int k = 0; k < NST; k++) begin
            nxt = stage - s_q.dly[k];
            if (dump_i) s_d.dly[k] = stage;
            stage = nxt;
        end
        shifted = $signed(stage) >>> shift_i;
        if (shifted > SAT_HI)      clamped = SAT_HI;
        else if (shifted < SAT_LO) clamped = SAT_LO;
        else                       clamped = shifted;
        if (dump_i) begin
            s_d.out   = OUT_W'(clamped);
            s_d.valid = 1'b1;
        end
        if (clear_i) s_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_o   = $signed(s_q.out);
    assign valid_o = s_q.valid;

endmodule

// File: rtl/beat_pe_cordic.sv
module beat_pe_cordic
    import beat_pe_pkg::*;
#(
    parameter int IN_W  = 24,
    parameter int PW    = 16,
    parameter int ITER  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear_i,
    input  logic                   start_i,
    input  logic signed [IN_W-1:0] x_i,
    input  logic signed [IN_W-1:0] y_i,
    output logic [PW-1:0]          phase_o,
    output logic                   valid_o
);
    localparam int XW = IN_W + 2;
    localparam int KW = $clog2(ITER + 1);
    localparam logic [ANG_W-1:0] RND = ANG_W'(1) << (ANG_W - 1 - PW);
    localparam logic [ANG_W-1:0] PI_W = ANG_W'(1) << (ANG_W - 1);

    typedef struct packed {
        logic                 busy;
        logic [KW-1:0]        k;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic [ANG_W-1:0]     z;
        logic [PW-1:0]        phase;
        logic                 valid;
    } cor_t;

    cor_t s_d, s_q;
    logic signed [XW-1:0] xs, ys, xe, ye;
    logic [ANG_W-1:0]     step;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        xs   = s_q.x >>> s_q.k;
        ys   = s_q.y >>> s_q.k;
        xe   = XW'(x_i);
        ye   = XW'(y_i);
        step = atan_word(int'(s_q.k));
        if (s_q.busy) begin
            if (s_q.y[XW-1]) begin
                s_d.x = s_q.x - ys;
                s_d.y = s_q.y + xs;
                s_d.z = s_q.z - step;
            end else begin
                s_d.x = s_q.x + ys;
                s_d.y = s_q.y - xs;
                s_d.z = s_q.z + step;
            end
            s_d.k = s_q.k + KW'(1);
            if (s_q.k == KW'(ITER - 1)) begin
                s_d.busy  = 1'b0;
                s_d.valid = 1'b1;
                s_d.phase = PW'((s_d.z + RND) >> (ANG_W - PW));
            end
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.k    = '0;
            if (xe[XW-1]) begin
                s_d.x = -xe;
                s_d.y = -ye;
                s_d.z = PI_W;
            end else begin
                s_d.x = xe;
                s_d.y = ye;
                s_d.z = '0;
            end
        end
        if (clear_i) begin
            s_d.busy  = 1'b0;
            s_d.valid = 1'b0;
            s_d.k     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign phase_o = s_q.phase;
    assign valid_o = s_q.valid;

endmodule

// File: rtl/beat_phase_est.sv
module beat_phase_est #(
    parameter int ADC_W   = 14,
    parameter int FREQ_W  = 32,
    parameter int SHIFT_W = 4,
    parameter int RATE_W  = 4,
    parameter int RMAX    = 13,
    parameter int CSH_W   = 6,
    parameter int LO_W    = 16,
    parameter int CORE_W  = 24,
    parameter int PHASE_W = 16,
    parameter int CORDIC_ITER = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADC_W-1:0]     adc_i,
    input  logic [FREQ_W-1:0]    diff_word_i,
    input  logic [SHIFT_W-1:0]   shift_i,
    input  logic [FREQ_W-1:0]    fixed_word_i,
    input  logic                 use_fixed_i,
    input  logic [RATE_W-1:0]    cic_rate_i,
    input  logic [CSH_W-1:0]     cic_shift_i,
    output logic [PHASE_W-1:0]   phase_o,
    output logic                 phase_valid_o
);
    localparam int MIX_W = ADC_W + 2;
    localparam int ACC_W = MIX_W + 3 * RMAX;
    localparam int CNT_W = RMAX + 1;

    typedef struct packed {
        logic [RATE_W-1:0]          rate;
        logic [CNT_W-1:0]           cnt;
        logic [1:0][MIX_W-1:0]      mix;
    } top_t;

    top_t s_d, s_q;

    logic signed [LO_W-1:0]       lo_cos, lo_nsin;
    logic signed [ADC_W+LO_W-1:0] prod_i, prod_q;
    logic [RATE_W-1:0]            rate_eff;
    logic [CNT_W-1:0]             win_m1;
    logic                         clear, last, dump;
    logic [1:0][CORE_W-1:0]       cic_out;
    logic [1:0]                   cic_valid;

    beat_pe_nco #(
        .FREQ_W(FREQ_W), .SHIFT_W(SHIFT_W), .LO_W(LO_W)
    ) u_nco (
        .clk(clk), .rst(rst),
        .diff_word_i(diff_word_i), .shift_i(shift_i),
        .fixed_word_i(fixed_word_i), .use_fixed_i(use_fixed_i),
        .cos_o(lo_cos), .nsin_o(lo_nsin)
    );

    always_comb begin
        s_d      = s_q;
        rate_eff = (cic_rate_i > RATE_W'(RMAX)) ? RATE_W'(RMAX) : cic_rate_i;
        win_m1   = (CNT_W'(1) << rate_eff) - CNT_W'(1);
        clear    = (cic_rate_i != s_q.rate);
        last     = (s_q.cnt == win_m1);
        dump     = last && !clear;
        prod_i   = $signed(adc_i) * lo_cos;
        prod_q   = $signed(adc_i) * lo_nsin;
        s_d.mix[0] = MIX_W'(prod_i >>> (LO_W - 2));
        s_d.mix[1] = MIX_W'(prod_q >>> (LO_W - 2));
        s_d.rate   = cic_rate_i;
        if (clear || last) s_d.cnt = '0;
        else               s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    for (genvar g = 0; g < 2; g++) begin : g_chan
        beat_pe_cic #(
            .IN_W(MIX_W), .ACC_W(ACC_W), .OUT_W(CORE_W), .CSH_W(CSH_W)
        ) u_cic (
            .clk(clk), .rst(rst), .clear_i(clear),
            .sample_i(s_q.mix[g]), .dump_i(dump), .shift_i(cic_shift_i),
            .out_o(cic_out[g]), .valid_o(cic_valid[g])
        );
    end

    beat_pe_cordic #(
        .IN_W(CORE_W), .PW(PHASE_W), .ITER(CORDIC_ITER)
    ) u_cordic (
        .clk(clk), .rst(rst), .clear_i(clear),
        .start_i(&cic_valid),
        .x_i(cic_out[0]), .y_i(cic_out[1]),
        .phase_o(phase_o), .valid_o(phase_valid_o)
    );

endmodule

// File: rtl/beat_pe_chk.sv
module beat_pe_chk #(
    parameter int RATE_W  = 4,
    parameter int RMAX    = 13,
    parameter int PHASE_W = 16,
    parameter int CORDIC_ITER = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [RATE_W-1:0]   cic_rate_i,
    input logic [PHASE_W-1:0]  phase_o,
    input logic                phase_valid_o
);
    logic [RATE_W-1:0] rate_prev_q;
    logic              seen_q;
    logic [31:0]       gap_q;
    logic [31:0]       win;

    assign win = (cic_rate_i > RATE_W'(RMAX)) ? (32'd1 << RMAX) : (32'd1 << cic_rate_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_prev_q <= '0;
            seen_q      <= 1'b0;
            gap_q       <= '0;
        end else begin
            rate_prev_q <= cic_rate_i;
            if (phase_valid_o) begin
                seen_q <= 1'b1;
                gap_q  <= '0;
            end else begin
                gap_q  <= gap_q + 32'd1;
            end
            if (cic_rate_i != rate_prev_q) seen_q <= 1'b0;
        end
    end

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        phase_valid_o |=> !phase_valid_o);

    assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_valid_o && seen_q && (cic_rate_i == rate_prev_q) && (win > CORDIC_ITER + 1))
        |-> (gap_q + 32'd1 == win));

    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_o != $past(phase_o)) |-> phase_valid_o);

    assert_rate_flush_R7: assert property (@(posedge clk) disable iff (rst)
        (cic_rate_i != rate_prev_q) |=> !phase_valid_o);

    assert_reset_quiet_R8: assert property (@(posedge clk)
        rst |=> (!phase_valid_o && phase_o == '0));

endmodule

bind beat_phase_est beat_pe_chk #(
    .RATE_W(RATE_W), .RMAX(RMAX), .PHASE_W(PHASE_W), .CORDIC_ITER(CORDIC_ITER)
) u_chk (
    .clk(clk), .rst(rst), .cic_rate_i(cic_rate_i),
    .phase_o(phase_o), .phase_valid_o(phase_valid_o)
);

// File: tb/sim_beat_phase_est.sv
module sim_beat_phase_est;
    localparam int CLK_PERIOD = 10;
    localparam int ITER = 16;
    localparam real TWO_PI = 6.283185307179586;
    localparam real AMP = 4000.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] adc = '0;
    logic [31:0] diff_word = '0;
    logic [3:0]  shift = '0;
    logic [31:0] fixed_word = '0;
    logic        use_fixed = 1'b0;
    logic [3:0]  rate = 4'd6;
    logic [5:0]  cshift = 6'd18;
    logic [15:0] phase;
    logic        pvalid;

    int checks = 0;
    int fails  = 0;
    real fin   = 1.0 / 16.0;
    real phi   = 0.0;
    real theta = 0.0;

    beat_phase_est #(
        .ADC_W(14), .FREQ_W(32), .SHIFT_W(4), .RATE_W(4), .RMAX(13),
        .CSH_W(6), .LO_W(16), .CORE_W(24), .PHASE_W(16), .CORDIC_ITER(ITER)
    ) u0 (
        .clk(clk), .rst(rst), .adc_i(adc),
        .diff_word_i(diff_word), .shift_i(shift),
        .fixed_word_i(fixed_word), .use_fixed_i(use_fixed),
        .cic_rate_i(rate), .cic_shift_i(cshift),
        .phase_o(phase), .phase_valid_o(pvalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // beat stimulus, updated away from the active edge
    initial begin
        forever begin
            real v;
            @(negedge clk);
            theta = theta + TWO_PI * fin;
            if (theta > TWO_PI) theta = theta - TWO_PI;
            v = AMP * $cos(theta + phi);
            adc = 14'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int pdiff(input int a, input int b);
        return int'($signed(16'(a - b)));
    endfunction

    task automatic near(input string req, input int act, input int exp_v, input int tol);
        int d;
        d = pdiff(act, exp_v);
        check((d <= tol) && (d >= -tol), req, act, exp_v);
    endtask

    task automatic next_phase(output int p);
        do @(negedge clk); while (!pvalid);
        p = int'(phase);
    endtask

    task automatic settle(input int n);
        int p;
        repeat (n) next_phase(p);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(pvalid == 1'b0, "R8 valid in reset", int'(pvalid), 0);
        check(phase == 16'd0, "R8 phase in reset", int'(phase), 0);
        rst = 1'b0;
    endtask

    task automatic t_derived_word();
        int p0, p1, p2;
        use_fixed = 1'b0;
        diff_word = 32'h2200_0000;   // 2^29 + 2^25: top part shifts out
        shift     = 4'd3;
        settle(6);
        next_phase(p0); next_phase(p1); next_phase(p2);
        near("R1 derived word matches beat", p1, p0, 48);
        near("R1 derived word stable", p2, p1, 48);
        diff_word = 32'h0208_0000;   // 2^25 + 2^19 -> LO above beat by 2^22
        settle(5);
        next_phase(p0); next_phase(p1);
        near("R6 rotation with derived offset", pdiff(p1, p0), -4096, 200);
    endtask

    task automatic t_fixed_word();
        int p0, p1;
        use_fixed  = 1'b1;
        fixed_word = 32'h1000_0000;
        diff_word  = 32'h1234_5677;
        shift      = 4'd5;
        settle(6);
        next_phase(p0); next_phase(p1);
        near("R2 fixed word ignores diff and shift", p1, p0, 48);
        fixed_word = 32'h0FC0_0000;  // below beat by 2^22
        settle(5);
        next_phase(p0); next_phase(p1);
        near("R2 R6 rotation with fixed offset", pdiff(p1, p0), 4096, 200);
        fixed_word = 32'h1000_0000;
        settle(5);
    endtask

    task automatic t_quadrants();
        int p0, p;
        phi = 0.0;
        settle(5); next_phase(p0);
        phi = TWO_PI / 4.0;
        settle(5); next_phase(p);
        near("R5 step +90 deg", p, p0 + 16384, 120);
        phi = TWO_PI / 2.0;
        settle(5); next_phase(p);
        near("R5 step 180 deg", p, p0 + 32768, 120);
        phi = -TWO_PI / 8.0;
        settle(5); next_phase(p);
        near("R5 step -45 deg", p, p0 - 8192, 120);
        phi = 0.0;
        settle(5);
    endtask

    task automatic t_saturation();
        int p0, p;
        next_phase(p0);
        phi = real'(pdiff(5461, p0)) * TWO_PI / 65536.0;
        settle(5); next_phase(p);
        near("R5 placed at 30 deg", p, 5461, 120);
        cshift = 6'd16;
        settle(5); next_phase(p);
        near("R4 smaller shift, no clamp", p, 5461, 120);
        cshift = 6'd0;
        settle(5); next_phase(p);
        near("R4 both channels clamp to 45 deg", p, 8192, 40);
        cshift = 6'd18;
        settle(5);
    endtask

    task automatic t_cadence();
        int n;
        settle(1);
        n = 0;
        do begin @(negedge clk); n++; end while (!pvalid);
        check(n == 64, "R3 spacing at R=6", n, 64);
        @(negedge clk);
        check(pvalid == 1'b0, "R3 single-cycle strobe", int'(pvalid), 0);
    endtask

    task automatic t_rate_change();
        int n, p;
        settle(1);
        rate   = 4'd8;
        cshift = 6'd24;
        n = 0;
        do begin @(negedge clk); n++; end while (!pvalid);
        check((n >= 256) && (n <= 256 + ITER + 8), "R7 first strobe after rate change", n, 256 + ITER + 2);
        n = 0;
        do begin @(negedge clk); n++; end while (!pvalid);
        check(n == 256, "R3 R7 spacing at R=8", n, 256);
        settle(4); next_phase(p);
        near("R7 restarted filter phase", p, 5461, 150);
        rate   = 4'd6;
        cshift = 6'd18;
        settle(5);
    endtask

    initial begin
        t_reset();
        t_derived_word();
        t_fixed_word();
        t_quadrants();
        t_saturation();
        t_cadence();
        t_rate_change();
        summary();
        $finish;
    end

endmodule